// File: doc/BRIEF.md
# Prioritized CPU Interrupt Selector

This block decides which asynchronous interruption class a processor accepts next, and hands the decision to the sequencer that performs the status-word swap. It looks at the enable bits of the current program status word, at the pending flags for machine check, external, clock-comparator and CPU-timer conditions, at the occupancy of the machine-check queue, the external queue and each I/O subclass queue, and at two control-register masks. When the `take` strobe is seen, it returns, for one cycle, a one-hot class, the interruption code, the chosen I/O subclass, and pulses that pop the served queue and clear the pending summaries that become empty.

Selection is combinational. A small three-state machine (IDLE, GRANT, FAULT) registers the result. In IDLE, a `take` moves the machine to GRANT when the decision is legal, or to FAULT when no class is eligible or the queue to be served has an invalid occupancy. GRANT and FAULT always return to IDLE on the next clock, and a `take` seen in either of them is ignored. This cooldown cycle gives the queue owner time to apply the pops before the next decision.

Top module: `irq_selector`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every output is zero.
- R2: When `sync_latched` is high, a `take` grants no class and raises `err`.
- R3: `grant` is one-hot, with bit 0 for machine check, bit 1 for external and bit 2 for I/O. The order of priority is machine check, then external, then I/O. A class is eligible only when its PSW enable input is high.
- R4: Machine check is eligible only when `chan_rpt_en` is high. When it is low, the class is skipped, lower classes may win, and no machine-check pop or clear is issued.
- R5: Inside the external class, a queued request (`pend_ext`) wins and returns `ext_code_in`. Otherwise a clock-comparator condition returns code 0x1004. Otherwise a CPU-timer condition returns code 0x1005.
- R6: When a clock-comparator or CPU-timer condition is delivered, `clr_ext` and `clr_ckc` both pulse and `pop_ext` stays low.
- R7: I/O subclasses are scanned from index 0 upward. The first one whose count field (`io_cnt[i*CW +: CW]`) is non-zero and whose `io_mask[i]` bit is set is served. `io_sub` gives its index and `pop_io` has only that bit set.
- R8: Each grant pops the served queue. The class's clear pulse is high only when the served count is 1. `clr_io` additionally requires every other subclass count, masked or not, to be zero.
- R9: A selected queue whose count is zero or greater than MAXD makes `err` pulse, with no grant, pop or clear.
- R10: A `take` with no eligible class makes `err` pulse, with every other output zero.
- R11: Outputs are registered pulses that appear in the cycle after `take` is sampled. With `take` low, no grant or error is ever issued.
- R12: A `take` sampled in the cycle that follows a grant or error pulse is ignored, and all outputs return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| take | input | 1 | Request for a decision |
| sync_latched | input | 1 | A program or supervisor-call exception is already latched |
| en_mchk | input | 1 | PSW machine-check enable |
| en_ext | input | 1 | PSW external enable |
| en_io | input | 1 | PSW I/O enable |
| pend_mchk | input | 1 | Machine-check summary pending |
| pend_ext | input | 1 | External queue summary pending |
| pend_ckc | input | 1 | Clock-comparator condition pending |
| pend_cpt | input | 1 | CPU-timer condition pending |
| chan_rpt_en | input | 1 | Channel-report enable (control register 14, bit 28) |
| mchk_cnt | input | CW | Machine-check queue occupancy |
| ext_cnt | input | CW | External queue occupancy |
| ext_code_in | input | 16 | Code of the external request at the queue top |
| io_cnt | input | NSUB*CW | Per-subclass I/O occupancy, subclass i at bits i*CW +: CW |
| io_mask | input | NSUB | Subclass enable mask (control register 6) |
| grant | output | 3 | One-hot granted class |
| int_code | output | 16 | External interruption code |
| io_sub | output | SW | Granted I/O subclass |
| pop_mchk | output | 1 | Pop the machine-check queue |
| pop_ext | output | 1 | Pop the external queue |
| pop_io | output | NSUB | Pop the marked I/O subclass queue |
| clr_mchk | output | 1 | Clear the machine-check summary |
| clr_ext | output | 1 | Clear the external summary |
| clr_ckc | output | 1 | Clear the clock-comparator flag |
| clr_io | output | 1 | Clear the I/O summary |
| err | output | 1 | Overrun or no eligible class |

## Verification
The hardest case to reach from the ports is an I/O grant whose `clr_io` depends on subclasses other than the one served. That happens when a masked lower subclass still holds entries while a higher unmasked one holds its last entry. A second sweep walks every combination of four count values per subclass against all sixteen masks, so those pairings all occur. The priority and enable paths come from a full sweep of the gating inputs, crossed with the occupancy values zero, one, two and above-maximum for the machine-check and external queues.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_FAULT = 2'd2
    } sel_state_e;

    typedef enum logic [1:0] {
        EXT_NONE  = 2'd0,
        EXT_QUEUE = 2'd1,
        EXT_CKC   = 2'd2,
        EXT_CPT   = 2'd3
    } ext_src_e;

    localparam int GR_MCHK = 0;
    localparam int GR_EXT  = 1;
    localparam int GR_IO   = 2;

    localparam logic [15:0] CODE_CKC = 16'h1004;
    localparam logic [15:0] CODE_CPT = 16'h1005;

endpackage

// File: rtl/irq_io_scan.sv
module irq_io_scan #(
    parameter int NSUB = 8,
    parameter int CW   = 4,
    parameter int MAXD = 8,
    localparam int SW  = (NSUB > 1) ? $clog2(NSUB) : 1
) (
    input  logic [NSUB*CW-1:0] cnt_flat,
    input  logic [NSUB-1:0]    mask,
    output logic               hit,
    output logic [SW-1:0]      sub,
    output logic [NSUB-1:0]    pick,
    output logic               ovr,
    output logic               last
);

    logic [NSUB-1:0] occ;
    logic [NSUB-1:0] elig;
    logic [CW-1:0]   sel_cnt;

    genvar g;
    generate
        for (g = 0; g < NSUB; g++) begin : g_sub
            assign occ[g]  = |cnt_flat[g*CW +: CW];
            assign elig[g] = occ[g] & mask[g];
        end
    endgenerate

    // lowest eligible index wins: walk downward so the last hit is the lowest
    always_comb begin
        sub  = '0;
        pick = '0;
        for (int i = NSUB - 1; i >= 0; i--) begin
            if (elig[i]) begin
                sub  = SW'(i);
                pick = NSUB'(1) << i;
            end
        end
    end

    assign hit     = |elig;
    assign sel_cnt = cnt_flat[int'(sub)*CW +: CW];
    assign ovr     = hit && (sel_cnt > CW'(MAXD));
    assign last    = hit && (sel_cnt == CW'(1)) && ((occ & ~pick) == '0);

endmodule

// File: rtl/irq_ext_pick.sv
module irq_ext_pick
    import irq_sel_pkg::*;
#(
    parameter int CW   = 4,
    parameter int MAXD = 8
) (
    input  logic          pend_ext,
    input  logic          pend_ckc,
    input  logic          pend_cpt,
    input  logic [CW-1:0] qcnt,
    input  logic [15:0]   qcode,
    output ext_src_e      src,
    output logic [15:0]   code,
    output logic          ovr,
    output logic          last
);

    always_comb begin
        if (pend_ext) begin
            src  = EXT_QUEUE;
            code = qcode;
        end else if (pend_ckc) begin
            src  = EXT_CKC;
            code = CODE_CKC;
        end else if (pend_cpt) begin
            src  = EXT_CPT;
            code = CODE_CPT;
        end else begin
            src  = EXT_NONE;
            code = 16'h0000;
        end
    end

    assign ovr  = (src == EXT_QUEUE) && ((qcnt == '0) || (qcnt > CW'(MAXD)));
    assign last = (src == EXT_QUEUE) && (qcnt == CW'(1));

endmodule

// File: rtl/irq_class_arb.sv
module irq_class_arb
    import irq_sel_pkg::*;
(
    input  logic       sync_latched,
    input  logic       mchk_rdy,
    input  logic       ext_rdy,
    input  logic       io_rdy,
    input  logic       mchk_ovr,
    input  logic       ext_ovr,
    input  logic       io_ovr,
    output logic [2:0] cls,
    output logic       bad
);

    always_comb begin
        cls = 3'b000;
        if (!sync_latched) begin
            if (mchk_rdy)      cls[GR_MCHK] = 1'b1;
            else if (ext_rdy)  cls[GR_EXT]  = 1'b1;
            else if (io_rdy)   cls[GR_IO]   = 1'b1;
        end
    end

    assign bad = (cls == 3'b000)
              || (cls[GR_MCHK] && mchk_ovr)
              || (cls[GR_EXT]  && ext_ovr)
              || (cls[GR_IO]   && io_ovr);

endmodule

// File: rtl/irq_selector.sv
module irq_selector
    import irq_sel_pkg::*;
#(
    parameter int NSUB = 8,
    parameter int CW   = 4,
    parameter int MAXD = 8,
    localparam int SW  = (NSUB > 1) ? $clog2(NSUB) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic               sync_latched,
    input  logic               en_mchk,
    input  logic               en_ext,
    input  logic               en_io,
    input  logic               pend_mchk,
    input  logic               pend_ext,
    input  logic               pend_ckc,
    input  logic               pend_cpt,
    input  logic               chan_rpt_en,
    input  logic [CW-1:0]      mchk_cnt,
    input  logic [CW-1:0]      ext_cnt,
    input  logic [15:0]        ext_code_in,
    input  logic [NSUB*CW-1:0] io_cnt,
    input  logic [NSUB-1:0]    io_mask,
    output logic [2:0]         grant,
    output logic [15:0]        int_code,
    output logic [SW-1:0]      io_sub,
    output logic               pop_mchk,
    output logic               pop_ext,
    output logic [NSUB-1:0]    pop_io,
    output logic               clr_mchk,
    output logic               clr_ext,
    output logic               clr_ckc,
    output logic               clr_io,
    output logic               err
);

    sel_state_e      state;
    sel_state_e      nxt;

    ext_src_e        ext_src;
    logic [15:0]     ext_code;
    logic            ext_ovr;
    logic            ext_last;

    logic            io_hit;
    logic [SW-1:0]   io_sel;
    logic [NSUB-1:0] io_pick;
    logic            io_ovr;
    logic            io_last;

    logic            mchk_rdy;
    logic            ext_rdy;
    logic            io_rdy;
    logic            mchk_ovr;
    logic            mchk_last;
    logic [2:0]      cls;
    logic            bad;
    logic            accept;

    irq_ext_pick #(.CW(CW), .MAXD(MAXD)) u_ext (
        .pend_ext (pend_ext),
        .pend_ckc (pend_ckc),
        .pend_cpt (pend_cpt),
        .qcnt     (ext_cnt),
        .qcode    (ext_code_in),
        .src      (ext_src),
        .code     (ext_code),
        .ovr      (ext_ovr),
        .last     (ext_last)
    );

    irq_io_scan #(.NSUB(NSUB), .CW(CW), .MAXD(MAXD)) u_io (
        .cnt_flat (io_cnt),
        .mask     (io_mask),
        .hit      (io_hit),
        .sub      (io_sel),
        .pick     (io_pick),
        .ovr      (io_ovr),
        .last     (io_last)
    );

    assign mchk_rdy  = en_mchk && pend_mchk && chan_rpt_en;
    assign ext_rdy   = en_ext && (ext_src != EXT_NONE);
    assign io_rdy    = en_io && io_hit;
    assign mchk_ovr  = (mchk_cnt == '0) || (mchk_cnt > CW'(MAXD));
    assign mchk_last = (mchk_cnt == CW'(1));

    irq_class_arb u_arb (
        .sync_latched (sync_latched),
        .mchk_rdy     (mchk_rdy),
        .ext_rdy      (ext_rdy),
        .io_rdy       (io_rdy),
        .mchk_ovr     (mchk_ovr),
        .ext_ovr      (ext_ovr),
        .io_ovr       (io_ovr),
        .cls          (cls),
        .bad          (bad)
    );

    assign accept = (state == ST_IDLE) && take;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions: IDLE -take,legal-> GRANT; IDLE -take,illegal-> FAULT;
    // GRANT -> IDLE; FAULT -> IDLE (take ignored in both)
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (take) nxt = bad ? ST_FAULT : ST_GRANT;
            ST_GRANT: nxt = ST_IDLE;
            ST_FAULT: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // registered one-cycle response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant    <= '0;
            int_code <= '0;
            io_sub   <= '0;
            pop_mchk <= 1'b0;
            pop_ext  <= 1'b0;
            pop_io   <= '0;
            clr_mchk <= 1'b0;
            clr_ext  <= 1'b0;
            clr_ckc  <= 1'b0;
            clr_io   <= 1'b0;
            err      <= 1'b0;
        end else begin
            grant    <= '0;
            int_code <= '0;
            io_sub   <= '0;
            pop_mchk <= 1'b0;
            pop_ext  <= 1'b0;
            pop_io   <= '0;
            clr_mchk <= 1'b0;
            clr_ext  <= 1'b0;
            clr_ckc  <= 1'b0;
            clr_io   <= 1'b0;
            err      <= 1'b0;
            if (accept) begin
                if (bad) begin
                    err <= 1'b1;
                end else begin
                    grant <= cls;
                    if (cls[GR_MCHK]) begin
                        pop_mchk <= 1'b1;
                        clr_mchk <= mchk_last;
                    end
                    if (cls[GR_EXT]) begin
                        int_code <= ext_code;
                        unique case (ext_src)
                            EXT_QUEUE: begin
                                pop_ext <= 1'b1;
                                clr_ext <= ext_last;
                            end
                            EXT_CKC, EXT_CPT: begin
                                clr_ext <= 1'b1;
                                clr_ckc <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                    if (cls[GR_IO]) begin
                        io_sub <= io_sel;
                        pop_io <= io_pick;
                        clr_io <= io_last;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/irq_sel_chk.sv
module irq_sel_chk #(
    parameter int NSUB = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            take,
    input logic            sync_latched,
    input logic            chan_rpt_en,
    input logic            en_ext,
    input logic [2:0]      grant,
    input logic            pop_mchk,
    input logic            pop_ext,
    input logic [NSUB-1:0] pop_io,
    input logic            clr_mchk,
    input logic            clr_ext,
    input logic            clr_ckc,
    input logic            clr_io,
    input logic            err
);

    assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_grant_needs_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != 3'b000 || err) |-> $past(take));

    assert_sync_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != 3'b000) |-> !$past(sync_latched));

    assert_mchk_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grant[0] |-> $past(chan_rpt_en));

    assert_ext_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant[1] |-> $past(en_ext));

    assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (grant == 3'b000 && !pop_mchk && !pop_ext && pop_io == '0
                 && !clr_mchk && !clr_ext && !clr_ckc && !clr_io));

    assert_io_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_io != '0) |-> ($onehot(pop_io) && grant[2]));

    assert_cooldown_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != 3'b000 || err) |=> (grant == 3'b000 && !err));

endmodule

bind irq_selector irq_sel_chk #(.NSUB(NSUB)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take),
    .sync_latched (sync_latched),
    .chan_rpt_en  (chan_rpt_en),
    .en_ext       (en_ext),
    .grant        (grant),
    .pop_mchk     (pop_mchk),
    .pop_ext      (pop_ext),
    .pop_io       (pop_io),
    .clr_mchk     (clr_mchk),
    .clr_ext      (clr_ext),
    .clr_ckc      (clr_ckc),
    .clr_io       (clr_io),
    .err          (err)
);

// File: tb/sim_irq_selector.sv
`timescale 1ns/1ps
module sim_irq_selector;

    localparam int NSUB = 4;
    localparam int CW   = 3;
    localparam int MAXD = 5;
    localparam int SW   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic take = 1'b0;
    logic sync_latched = 1'b0;
    logic en_mchk = 1'b0, en_ext = 1'b0, en_io = 1'b0;
    logic pend_mchk = 1'b0, pend_ext = 1'b0, pend_ckc = 1'b0, pend_cpt = 1'b0;
    logic chan_rpt_en = 1'b0;
    logic [CW-1:0] mchk_cnt = '0, ext_cnt = '0;
    logic [15:0] ext_code_in = '0;
    logic [NSUB*CW-1:0] io_cnt = '0;
    logic [NSUB-1:0] io_mask = '0;

    logic [2:0] grant;
    logic [15:0] int_code;
    logic [SW-1:0] io_sub;
    logic pop_mchk, pop_ext, clr_mchk, clr_ext, clr_ckc, clr_io, err;
    logic [NSUB-1:0] pop_io;

    int n_chk = 0;
    int n_bad = 0;

    // expected values
    logic [2:0] e_grant;
    logic [15:0] e_code;
    logic [SW-1:0] e_sub;
    logic e_pm, e_pe, e_cm, e_ce, e_cc, e_ci, e_err;
    logic [NSUB-1:0] e_pio;
    int e_cls;
    logic e_timer;

    always #2 clk = ~clk;

    irq_selector #(.NSUB(NSUB), .CW(CW), .MAXD(MAXD)) u0 (
        .clk(clk), .rst_n(rst_n), .take(take), .sync_latched(sync_latched),
        .en_mchk(en_mchk), .en_ext(en_ext), .en_io(en_io),
        .pend_mchk(pend_mchk), .pend_ext(pend_ext), .pend_ckc(pend_ckc),
        .pend_cpt(pend_cpt), .chan_rpt_en(chan_rpt_en),
        .mchk_cnt(mchk_cnt), .ext_cnt(ext_cnt), .ext_code_in(ext_code_in),
        .io_cnt(io_cnt), .io_mask(io_mask),
        .grant(grant), .int_code(int_code), .io_sub(io_sub),
        .pop_mchk(pop_mchk), .pop_ext(pop_ext), .pop_io(pop_io),
        .clr_mchk(clr_mchk), .clr_ext(clr_ext), .clr_ckc(clr_ckc),
        .clr_io(clr_io), .err(err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] cv(input int k);
        case (k)
            0: return 3'd0;
            1: return 3'd1;
            2: return 3'd2;
            default: return 3'd6;
        endcase
    endfunction

    function automatic logic [CW-1:0] iocnt(input int s);
        return io_cnt[s*CW +: CW];
    endfunction

    task automatic model();
        int s;
        logic others;
        e_grant = 0; e_code = 0; e_sub = 0; e_pio = 0; e_err = 0;
        e_pm = 0; e_pe = 0; e_cm = 0; e_ce = 0; e_cc = 0; e_ci = 0;
        e_cls = 0; e_timer = 0;
        s = -1;
        for (int i = NSUB - 1; i >= 0; i--)
            if (iocnt(i) != 0 && io_mask[i]) s = i;
        if (!sync_latched) begin
            if (en_mchk && pend_mchk && chan_rpt_en) e_cls = 1;
            else if (en_ext && (pend_ext || pend_ckc || pend_cpt)) e_cls = 2;
            else if (en_io && s >= 0) e_cls = 3;
        end
        case (e_cls)
            0: e_err = 1;
            1: if (mchk_cnt == 0 || mchk_cnt > MAXD) e_err = 1;
               else begin e_grant = 3'b001; e_pm = 1; e_cm = (mchk_cnt == 1); end
            2: if (pend_ext) begin
                   if (ext_cnt == 0 || ext_cnt > MAXD) e_err = 1;
                   else begin
                       e_grant = 3'b010; e_code = ext_code_in; e_pe = 1;
                       e_ce = (ext_cnt == 1);
                   end
               end else begin
                   e_timer = 1; e_grant = 3'b010; e_ce = 1; e_cc = 1;
                   e_code = pend_ckc ? 16'h1004 : 16'h1005;
               end
            default: if (iocnt(s) > MAXD) e_err = 1;
               else begin
                   e_grant = 3'b100; e_sub = SW'(s); e_pio = NSUB'(1) << s;
                   others = 0;
                   for (int i = 0; i < NSUB; i++) if (i != s && iocnt(i) != 0) others = 1;
                   e_ci = (iocnt(s) == 1) && !others;
               end
        endcase
    endtask

    task automatic compare_all();
        string tg, te, tc;
        tg = (en_mchk && pend_mchk && !chan_rpt_en && !sync_latched) ? "R4" : "R3";
        te = (e_cls == 0) ? (sync_latched ? "R2" : "R10") : "R9";
        tc = e_timer ? "R6" : "R8";
        chk(tg, "grant", grant, e_grant);
        chk("R5", "int_code", int_code, e_code);
        chk("R7", "io_sub", io_sub, e_sub);
        chk("R7", "pop_io", pop_io, e_pio);
        chk(tc, "pops", {pop_mchk, pop_ext}, {e_pm, e_pe});
        chk(tc, "clears", {clr_mchk, clr_ext, clr_ckc, clr_io}, {e_cm, e_ce, e_cc, e_ci});
        chk(te, "err", err, e_err);
    endtask

    task automatic fire();
        take = 1;
        @(posedge clk); @(negedge clk);
        take = 0;
        model();
        compare_all();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic check_quiet(input string tag);
        chk(tag, "grant", grant, 0);
        chk(tag, "err", err, 0);
        chk(tag, "pops", {pop_mchk, pop_ext, pop_io}, 0);
        chk(tag, "clears", {clr_mchk, clr_ext, clr_ckc, clr_io}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R11 watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state with stimulus present
        en_mchk = 1; pend_mchk = 1; chan_rpt_en = 1; mchk_cnt = 1; take = 1;
        repeat (3) @(negedge clk);
        check_quiet("R1");
        take = 0;
        rst_n = 1;
        @(negedge clk);
        check_quiet("R1");

        // R11: no take, everything pending
        en_ext = 1; en_io = 1; pend_ext = 1; ext_cnt = 2; io_mask = '1; io_cnt = 12'o1111;
        repeat (4) begin
            @(negedge clk);
            check_quiet("R11");
        end

        // R12: take held across the grant cycle
        en_mchk = 0; pend_ext = 0; pend_ckc = 1;
        take = 1;
        @(posedge clk); @(negedge clk);
        chk("R11", "grant after take", grant, 3'b010);
        chk("R6", "clr_ckc", clr_ckc, 1);
        @(posedge clk); @(negedge clk);
        check_quiet("R12");
        take = 0;
        @(posedge clk); @(negedge clk);

        // sweep of gating inputs and queue occupancies
        io_cnt = {3'd0, 3'd1, 3'd2, 3'd0};
        io_mask = 4'b0110;
        for (int idx = 0; idx < 8192; idx++) begin
            sync_latched = idx[0];
            en_mchk = idx[1]; en_ext = idx[2]; en_io = idx[3];
            pend_mchk = idx[4]; pend_ext = idx[5]; pend_ckc = idx[6]; pend_cpt = idx[7];
            chan_rpt_en = idx[8];
            mchk_cnt = cv((idx >> 9) & 3);
            ext_cnt = cv((idx >> 11) & 3);
            ext_code_in = {idx[7:0], idx[12:5]} ^ 16'h5A3C;
            fire();
        end

        // I/O subclass sweep
        sync_latched = 0; en_mchk = 0; en_ext = 0; en_io = 1;
        pend_mchk = 0; pend_ext = 0; pend_ckc = 0; pend_cpt = 0;
        for (int pat = 0; pat < 256; pat++) begin
            for (int m = 0; m < 16; m++) begin
                for (int i = 0; i < NSUB; i++) io_cnt[i*CW +: CW] = cv((pat >> (2*i)) & 3);
                io_mask = m[3:0];
                fire();
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule